// File: doc/BRIEF.md
# Watchdog Timer with Selectable NMI or Reset Expiry

This block is a software watchdog. A 10-bit counter advances once per slow tick enable (nominally 256 Hz, derived from a 32.768 kHz source), so a full period is 1024 ticks, about 4 seconds. Firmware that is alive writes a restart strobe before the period runs out. If it does not, the counter reaches its last value. The next tick then raises a request to the CPU.

A small register interface controls the timer. The interface holds a 4-bit run/stop code, a mode bit and the restart strobe, and it reads back the count. The counter runs only while the run/stop field holds one specific key value. Any other value halts it, so a stray write is unlikely to start the timer. The mode bit chooses where an expiry goes: a non-maskable interrupt request or a CPU reset request. Each request is a single-cycle pulse in the system clock domain. After an expiry the counter wraps to zero and keeps counting.

Top module: `wdt_nmi_rst`

## Requirements
- R1: After reset the count is 0, the run/stop field reads 4'b0101 (halted), the mode bit reads 0 (NMI), and both request outputs are low.
- R2: While the run/stop field holds 4'b1010, each clock edge with `tick` high increments the count by one. Edges without `tick` leave the count unchanged.
- R3: With any run/stop value other than 4'b1010, the count holds its value whatever `tick` does, and no request pulse is produced.
- R4: A tick that arrives while running with the count at 1023 wraps the count to 0. After that same edge, `nmi_req` is high for one cycle when the mode bit is 0, or `rst_req` is high when it is 1. Counting then continues from 0.
- R5: A write to address 1 with `bus_wdata[0]`=1 clears the count to 0. A write to address 1 with `bus_wdata[0]`=0 has no effect.
- R6: A restart write in the same cycle as a tick wins. The count becomes 0, and no request is raised even if the count was 1023.
- R7: A write to address 0 loads run/stop from `bus_wdata[3:0]` and the mode bit from `bus_wdata[4]`. Reading address 0 returns mode in bit 4 and run/stop in bits 3:0. Reading address 2 returns the count in bits 9:0. All other bits, and address 3, read as zero.
- R8: `nmi_req` and `rst_req` are never high together, and each pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow tick enable, one clock wide per tick |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 restart, 2 count |
| bus_wdata | input | 5 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| nmi_req | output | 1 | Non-maskable interrupt request pulse |
| rst_req | output | 1 | CPU reset request pulse |

## Verification
A tick or a write acts at the next rising edge. The count and readback change at that edge and are visible on `bus_rdata` as soon as the address is set. An expiry pulse appears on `nmi_req` or `rst_req` right after the edge that wraps the count, and is gone one edge later. The bench drives inputs on falling edges, reads registers a moment after a falling edge, and samples the request outputs at every falling edge. Before each run of ticks that should expire, the driver queues the pulse it expects. The monitor compares every pulse it sees against that queue, so a missing, extra, misrouted or stretched pulse counts as a miscompare.

// File: rtl/wdt_nmi_rst.sv
module wdt_nmi_rst #(
  parameter int         CNT_W     = 10,
  parameter int         DW        = 16,
  parameter logic [3:0] RUN_KEY   = 4'b1010,
  parameter logic [3:0] HALT_INIT = 4'b0101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [4:0]    bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          nmi_req,
  output logic          rst_req
);

  localparam logic [1:0]       A_CTRL  = 2'd0;
  localparam logic [1:0]       A_KICK  = 2'd1;
  localparam logic [1:0]       A_CNT   = 2'd2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [3:0]       run_code;
  logic             sel_rst;
  logic [CNT_W-1:0] cnt;

  wire running = (run_code == RUN_KEY);
  wire ctrl_wr = bus_we && (bus_addr == A_CTRL);
  wire kick    = bus_we && (bus_addr == A_KICK) && bus_wdata[0];
  wire step    = running && tick;
  wire expire  = step && (cnt == CNT_MAX) && !kick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_code <= HALT_INIT;
      sel_rst  <= 1'b0;
      cnt      <= '0;
      nmi_req  <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run_code <= bus_wdata[3:0];
        sel_rst  <= bus_wdata[4];
      end
      if (kick)      cnt <= '0;
      else if (step) cnt <= cnt + CNT_W'(1);
      nmi_req <= expire && !sel_rst;
      rst_req <= expire && sel_rst;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'({sel_rst, run_code});
      A_CNT:   bus_rdata = DW'(cnt);
      default: bus_rdata = '0;
    endcase
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !kick) |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !kick) |=> (cnt == $past(cnt)));

  assert_pulse_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req || rst_req) |-> $past(running && tick));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req || rst_req) |-> (cnt == '0));

  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0 && !nmi_req && !rst_req));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_req && rst_req));

  assert_nmi_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |=> !nmi_req);

  assert_rst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

endmodule

// File: tb/wdt_nmi_rst_tb.sv
module wdt_nmi_rst_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [4:0]  bus_wdata = 5'd0;
  logic [15:0] bus_rdata;
  logic        nmi_req, rst_req;

  int vectors = 0;
  int errors  = 0;
  bit exp_q[$];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wdt_nmi_rst u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_req(nmi_req), .rst_req(rst_req)
  );

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    vectors++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s: addr %0d read 0x%h, expected 0x%h", tag, a, bus_rdata, exp);
    end
  endtask

  // monitor: every request pulse must match the next queued expectation (R4, R8)
  always @(negedge clk) begin
    if (rst_n && (nmi_req || rst_req)) begin
      vectors++;
      if (nmi_req && rst_req) begin
        errors++;
        $display("FAIL R8: both requests high, expected one");
      end else if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R3/R6/R8: unexpected pulse nmi=%0b rst=%0b, expected none", nmi_req, rst_req);
      end else begin
        bit want_rst;
        want_rst = exp_q.pop_front();
        if (rst_req !== want_rst) begin
          errors++;
          $display("FAIL R4: pulse rst=%0b, expected rst=%0b", rst_req, want_rst);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    vectors++;
    if (nmi_req !== 1'b0 || rst_req !== 1'b0) begin
      errors++;
      $display("FAIL R1: requests %0b%0b, expected 00", nmi_req, rst_req);
    end
    rd(2'd0, 16'h0005, "R1");
    rd(2'd2, 16'h0000, "R1");
    rd(2'd3, 16'h0000, "R7");

    // R3 halted at reset code
    ticks(5);
    rd(2'd2, 16'h0000, "R3");

    // R2 run, count ticks
    wr(2'd0, 5'h0A);
    rd(2'd0, 16'h000A, "R7");
    ticks(7);
    rd(2'd2, 16'h0007, "R2");
    repeat (3) @(negedge clk);
    rd(2'd2, 16'h0007, "R2");

    // R3 other code halts
    wr(2'd0, 5'h0B);
    ticks(4);
    rd(2'd2, 16'h0007, "R3");
    wr(2'd0, 5'h0A);

    // R5 restart
    wr(2'd1, 5'h00);
    rd(2'd2, 16'h0007, "R5");
    wr(2'd1, 5'h01);
    rd(2'd2, 16'h0000, "R5");

    // R4 NMI expiry
    exp_q.push_back(1'b0);
    ticks(1024);
    rd(2'd2, 16'h0000, "R4");
    ticks(3);
    rd(2'd2, 16'h0003, "R4");

    // R4 reset-mode expiry
    wr(2'd0, 5'h1A);
    rd(2'd0, 16'h001A, "R7");
    exp_q.push_back(1'b1);
    ticks(1021);
    rd(2'd2, 16'h0000, "R4");

    // R6 restart beats tick at 1023
    ticks(1023);
    rd(2'd2, 16'h03FF, "R6");
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 5'h01; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
    rd(2'd2, 16'h0000, "R6");
    repeat (4) @(negedge clk);

    // R3 halted at 1023: no expiry
    ticks(1023);
    wr(2'd0, 5'h15);
    rd(2'd0, 16'h0015, "R7");
    ticks(10);
    rd(2'd2, 16'h03FF, "R3");
    repeat (4) @(negedge clk);

    vectors++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R4: %0d pulses missing, expected 0", exp_q.size());
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule